// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block turns a small CPU-visible register file into the address translation that lets a 32 KB CPU program region and an 8 KB graphics pattern region reach much larger program and pattern ROMs. The CPU writes bank numbers into registers that sit in the 0x8000–0xFFFF range. The block then turns every program read offset and every pattern read address into a full ROM address. It also holds one bit that picks the nametable mirroring arrangement.

The program region is split into four 8 KB windows. The lower two windows can be switched. The upper two always show the last two banks of the program ROM. The pattern region is split into eight 1 KB slots, and each slot has its own bank register. Register writes are decoded only from address bits 15:12 and 1:0. A write is applied on the clock edge that samples the write strobe. Read translation is combinational from the stored bank values.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, both switchable program windows use bank 0, all eight pattern slots use bank 0, and `mirror_horiz` is 0 (vertical).
- R2: A write whose address matches 0x8000 under the mask 0xF003 loads the bank for program offsets 0x0000–0x1FFF (CPU 0x8000–0x9FFF). The other window is left unchanged.
- R3: A write matching 0xA000 under the mask loads the bank for program offsets 0x2000–0x3FFF (CPU 0xA000–0xBFFF). The other window is left unchanged.
- R4: Program offsets 0x4000–0x5FFF always map to bank 2^PRG_BANKS_LOG2−2, and offsets 0x6000–0x7FFF always map to bank 2^PRG_BANKS_LOG2−1, whatever registers are written.
- R5: Pattern slot n covers pattern addresses n·0x400 to n·0x400+0x3FF. Slots 0..7 are loaded by writes matching 0xB000, 0xB002, 0xC000, 0xC002, 0xD000, 0xD002, 0xE000 and 0xE002 respectively.
- R6: A write matching 0x9000 sets `mirror_horiz` to data bit 0. A value of 1 means horizontal and 0 means vertical. Data bits 7:1 have no effect.
- R7: A write with CPU address bit 15 clear changes no register.
- R8: A write at or above 0x8000 whose masked address has no register, such as 0x8001, 0xA002, 0xB001 or 0xF000, changes no register.
- R9: The bank used is the 8-bit register value modulo the bank count, which means its low PRG_BANKS_LOG2 or CHR_BANKS_LOG2 bits.
- R10: A write is visible on the outputs after the clock edge that samples it. A change of read address changes the ROM address in the same cycle, with no clock edge.
- R11: The ROM address is the bank number placed above the unchanged in-window offset: 13 offset bits for program reads and 10 for pattern reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| prg_raddr | input | 15 | Read offset inside the 32 KB program region (CPU address minus 0x8000) |
| prg_rom_addr | output | PRG_BANKS_LOG2+13 | Program ROM byte address |
| chr_raddr | input | 13 | Pattern-table read address |
| chr_rom_addr | output | CHR_BANKS_LOG2+10 | Pattern ROM byte address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The hardest case to reach from the ports is a write that misses. It can be below 0x8000, at an odd offset, at offset 2 of a page that has no paired register, or to the unused 0xF000 page. Such a write must leave every register as it was, and a miss only shows if the register it might have hit already holds a value that differs from the data written. The vector table therefore loads distinct values into each register first, then sends near-miss writes carrying new data, and reads back the window or slot that each near-miss would have hit. Modulo wrap is covered by bank values with high bits set, on a bench built with small bank counts.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_SLOTS  = 8;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int PRG_OFF_W  = 13;
    localparam int CHR_OFF_W  = 10;

    typedef struct packed {
        logic [REG_W-1:0]                 prg0;
        logic [REG_W-1:0]                 prg1;
        logic [NUM_SLOTS-1:0][REG_W-1:0]  chr;
        logic                             mirror;
    } bank_regs_t;

    typedef struct packed {
        logic                 prg0;
        logic                 prg1;
        logic                 mirror;
        logic [NUM_SLOTS-1:0] chr;
    } wr_sel_t;
endpackage

// File: rtl/cbk_decode.sv
module cbk_decode
    import cbk_pkg::*;
(
    input  logic        wr,
    input  logic [15:0] addr,
    output wr_sel_t     sel
);
    logic [2:0] page;
    logic [2:0] pair;

    always_comb begin
        sel  = '0;
        page = addr[14:12];
        pair = page - 3'd3;
        if (wr && addr[15] && !addr[0]) begin
            if (!addr[1]) begin
                case (page)
                    3'd0:    sel.prg0   = 1'b1;
                    3'd1:    sel.mirror = 1'b1;
                    3'd2:    sel.prg1   = 1'b1;
                    default: ;
                endcase
            end
            if (page >= 3'd3 && page <= 3'd6)
                sel.chr[{pair[1:0], addr[1]}] = 1'b1;
        end
    end
endmodule

// File: rtl/cbk_regfile.sv
module cbk_regfile
    import cbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wr_sel_t          sel,
    input  logic [REG_W-1:0] wdata,
    output bank_regs_t       regs
);
    bank_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sel.prg0)   regs_d.prg0   = wdata;
        if (sel.prg1)   regs_d.prg1   = wdata;
        if (sel.mirror) regs_d.mirror = wdata[0];
        for (int s = 0; s < NUM_SLOTS; s++)
            if (sel.chr[s]) regs_d.chr[s] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    a_r2_prg0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel.prg0 |=> $stable(regs_q.prg0));
    a_r3_prg1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel.prg1 |=> $stable(regs_q.prg1));
    a_r6_mirror_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        sel.mirror |=> regs_q.mirror == $past(wdata[0]));
    a_r5_chr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.chr == '0) |=> $stable(regs_q.chr));
endmodule

// File: rtl/cbk_prg_map.sv
module cbk_prg_map
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 8
) (
    input  logic [14:0]                         raddr,
    input  logic [REG_W-1:0]                    bank0,
    input  logic [REG_W-1:0]                    bank1,
    output logic [PRG_BANKS_LOG2+PRG_OFF_W-1:0] rom_addr
);
    localparam logic [PRG_BANKS_LOG2-1:0] LAST_BANK = '1;
    localparam logic [PRG_BANKS_LOG2-1:0] NEXT_LAST = LAST_BANK - 1'b1;

    logic [PRG_BANKS_LOG2-1:0] bank;

    always_comb begin
        case (raddr[14:13])
            2'd0:    bank = bank0[PRG_BANKS_LOG2-1:0];
            2'd1:    bank = bank1[PRG_BANKS_LOG2-1:0];
            2'd2:    bank = NEXT_LAST;
            default: bank = LAST_BANK;
        endcase
        rom_addr = {bank, raddr[PRG_OFF_W-1:0]};
    end
endmodule

// File: rtl/cbk_chr_map.sv
module cbk_chr_map
    import cbk_pkg::*;
#(
    parameter int CHR_BANKS_LOG2 = 8
) (
    input  logic [SLOT_IDX_W+CHR_OFF_W-1:0]         raddr,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]         banks,
    output logic [CHR_BANKS_LOG2+CHR_OFF_W-1:0]     rom_addr
);
    logic [REG_W-1:0] sel_bank;

    always_comb begin
        sel_bank = banks[raddr[SLOT_IDX_W+CHR_OFF_W-1:CHR_OFF_W]];
        rom_addr = {sel_bank[CHR_BANKS_LOG2-1:0], raddr[CHR_OFF_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbk_pkg::*;
#(
    parameter int PRG_BANKS_LOG2 = 8,
    parameter int CHR_BANKS_LOG2 = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cpu_wr,
    input  logic [15:0]                           cpu_addr,
    input  logic [7:0]                            cpu_wdata,
    input  logic [14:0]                           prg_raddr,
    output logic [PRG_BANKS_LOG2+PRG_OFF_W-1:0]   prg_rom_addr,
    input  logic [12:0]                           chr_raddr,
    output logic [CHR_BANKS_LOG2+CHR_OFF_W-1:0]   chr_rom_addr,
    output logic                                  mirror_horiz
);
    wr_sel_t    sel;
    bank_regs_t regs;

    cbk_decode u_decode (
        .wr   (cpu_wr),
        .addr (cpu_addr),
        .sel  (sel)
    );

    cbk_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wdata (cpu_wdata),
        .regs  (regs)
    );

    cbk_prg_map #(.PRG_BANKS_LOG2(PRG_BANKS_LOG2)) u_prg (
        .raddr    (prg_raddr),
        .bank0    (regs.prg0),
        .bank1    (regs.prg1),
        .rom_addr (prg_rom_addr)
    );

    cbk_chr_map #(.CHR_BANKS_LOG2(CHR_BANKS_LOG2)) u_chr (
        .raddr    (chr_raddr),
        .banks    (regs.chr),
        .rom_addr (chr_rom_addr)
    );

    assign mirror_horiz = regs.mirror;

    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    a_r7_low_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[15]) |=> $stable(mirror_horiz) && $stable(regs));
    a_r4_last_window: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_raddr[14:13] == 2'b11) |->
            (prg_rom_addr[PRG_BANKS_LOG2+PRG_OFF_W-1:PRG_OFF_W] == '1));
    a_r11_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        chr_rom_addr[CHR_OFF_W-1:0] == chr_raddr[CHR_OFF_W-1:0]);
endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
    localparam int PL = 4;
    localparam int CL = 5;
    localparam int NPRG = 1 << PL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [14:0] prg_raddr = '0;
    logic [12:0] chr_raddr = '0;
    logic [PL+12:0] prg_rom_addr;
    logic [CL+9:0]  chr_rom_addr;
    logic        mirror_horiz;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cart_bank_ctrl #(.PRG_BANKS_LOG2(PL), .CHR_BANKS_LOG2(CL)) i_cart_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .prg_raddr(prg_raddr), .prg_rom_addr(prg_rom_addr),
        .chr_raddr(chr_raddr), .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
    );

    // {write addr, write data, 1=pattern read, CPU/pattern read address, expected bank}
    localparam int NV = 19;
    localparam logic [48:0] VEC [NV] = '{
        {16'h8000, 8'h05, 1'b0, 16'h8123, 8'd5},   // R2
        {16'hA000, 8'h03, 1'b0, 16'hA000, 8'd3},   // R3
        {16'h8000, 8'h17, 1'b0, 16'h9FFF, 8'd7},   // R9 wrap
        {16'hB000, 8'h21, 1'b1, 16'h0005, 8'd1},   // R5 slot0, R9
        {16'hB002, 8'h04, 1'b1, 16'h0400, 8'd4},   // R5
        {16'hC000, 8'h02, 1'b1, 16'h0BFF, 8'd2},   // R5
        {16'hC002, 8'h05, 1'b1, 16'h0C10, 8'd5},   // R5
        {16'hD000, 8'h06, 1'b1, 16'h1000, 8'd6},   // R5
        {16'hD002, 8'h07, 1'b1, 16'h1555, 8'd7},   // R5
        {16'hE000, 8'h08, 1'b1, 16'h1800, 8'd8},   // R5
        {16'hE002, 8'h09, 1'b1, 16'h1FFF, 8'd9},   // R5
        {16'h8001, 8'h0B, 1'b0, 16'h8000, 8'd7},   // R8 odd offset
        {16'hB001, 8'h1F, 1'b1, 16'h0000, 8'd1},   // R8
        {16'h7000, 8'h0C, 1'b0, 16'h8000, 8'd7},   // R7 below 0x8000
        {16'h0000, 8'h0D, 1'b0, 16'hA001, 8'd3},   // R7
        {16'hF000, 8'h03, 1'b0, 16'hE000, 8'd15},  // R8 unused page, R4
        {16'hA002, 8'h02, 1'b0, 16'hA000, 8'd3},   // R8 unpaired offset
        {16'h8000, 8'hFF, 1'b0, 16'hC000, 8'd14},  // R4 fixed window
        {16'h9002, 8'h0A, 1'b1, 16'h1C00, 8'd9}    // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_prg(input string req, input logic [15:0] a, input int bank);
        prg_raddr = a[14:0];
        #1;
        check(req, 32'(prg_rom_addr), 32'((bank << 13) | int'(a[12:0])));
    endtask

    task automatic rd_chr(input string req, input logic [12:0] a, input int bank);
        chr_raddr = a;
        #1;
        check(req, 32'(chr_rom_addr), 32'((bank << 10) | int'(a[9:0])));
    endtask

    task automatic reset_checks(input string req);
        rd_prg(req, 16'h8000, 0);
        rd_prg(req, 16'hA7FF, 0);
        rd_prg(req, 16'hC000, NPRG - 2);
        rd_prg(req, 16'hE001, NPRG - 1);
        for (int s = 0; s < 8; s++) rd_chr(req, 13'(s * 1024 + 3), 0);
        check(req, 32'(mirror_horiz), 0);
    endtask

    initial begin
        #200_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_checks("R1");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][48:33], VEC[i][32:25]);
            if (VEC[i][24]) rd_chr("R5/R7/R8/R9/R11", VEC[i][20:8], int'(VEC[i][7:0]));
            else            rd_prg("R2/R3/R4/R7/R8/R9/R11", VEC[i][23:8], int'(VEC[i][7:0]));
        end

        // R6 mirroring
        wr(16'h9000, 8'h01); check("R6", 32'(mirror_horiz), 1);
        wr(16'h9000, 8'hFE); check("R6", 32'(mirror_horiz), 0);
        wr(16'h9000, 8'h03); check("R6", 32'(mirror_horiz), 1);
        wr(16'h1000, 8'h00); check("R7", 32'(mirror_horiz), 1);
        wr(16'h9001, 8'h00); check("R8", 32'(mirror_horiz), 1);
        wr(16'h9003, 8'h00); check("R8", 32'(mirror_horiz), 1);

        // R10 timing: not visible before the sampling edge, visible after it
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'hA000; cpu_wdata = 8'h06;
        rd_prg("R10", 16'hA000, 3);
        @(negedge clk);
        cpu_wr = 1'b0;
        rd_prg("R10", 16'hA000, 6);
        rd_prg("R10", 16'h8000, 15);

        // R1 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reset_checks("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule